// File: doc/BRIEF.md
# YCbCr 4:2:2 Input Demultiplexer

This block sits at the input of a video output path and turns 4:2:2 component samples into one aligned pixel at a time: a luma value together with the co-sited Cb/Cr pair. It accepts two arrangements. In the two-bus arrangement a primary bus carries one luma word per clock and a secondary bus carries chroma, Cb and Cr on alternate clocks. In the shared-bus arrangement a single bus carries the repeating word order Cb, Y, Cr, Y at twice the pixel rate.

The chroma order is fixed by a phase reference. With sync timing, the word sampled on the first clock at which the horizontal sync input reaches its active level is taken as Cb. With embedded timing, a start-of-active-video timing code on the primary bus fixes the order, and the word right after it is Cb. An 8-bit narrow option places data in the upper eight bits of each bus and clears the two lowest bits. Each pixel pair comes out as two pixels. The first pixel carries the chroma pair and is flagged as co-sited. The second pixel repeats the same chroma for a later interpolation stage.

Top module: `ycc422_demux`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs are cleared to zero after that edge.
- R2: In two-bus mode (mode_sel=0), a Cb word on bus_b sampled at edge E together with Y0 on bus_a, followed by Cr and Y1 at edge E+1, gives pixel {Y0, Cb, Cr} after edge E+2 and pixel {Y1, Cb, Cr} after edge E+3. In steady state pix_valid is high on every clock.
- R3: In shared-bus mode (mode_sel=1), bus_a carries Cb, Y0, Cr and Y1 at edges E to E+3. This gives pixel {Y0, Cb, Cr} after E+4 and pixel {Y1, Cb, Cr} after E+6. pix_valid is never high on two clocks in a row.
- R4: With sync timing (timing_sel=0), the word sampled on the first edge at which hs_in equals the active level is taken as Cb. Holding hs_in active afterwards causes no further realignment.
- R5: hs_pol selects the active level of hs_in: 1 means active high and 0 means active low.
- R6: With embedded timing (timing_sel=1), the words 3FF, 000, 000, XY on bus_a at consecutive edges, where XY bit 9 is 1 and bit 6 is 0, mark the start of active video. The word at the next edge is taken as Cb. hs_in has no effect in this mode.
- R7: A timing code whose XY bit 6 is 1 (end of active video) does not change the chroma order.
- R8: With narrow_en=1, bits [1:0] of both buses are taken as zero before any use, timing-code matching included.
- R9: An edge at which mode_sel differs from its value at the previous edge discards the sampled word and any pixel not yet shown, and leaves pix_valid low after that edge. The word at the following edge is taken as Cb.
- R10: cosited is high only on the first pixel of each pair. The second pixel keeps cb_out and cr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 two-bus, 1 shared bus |
| timing_sel | input | 1 | 0 sync input, 1 embedded timing codes |
| hs_pol | input | 1 | Active level of hs_in |
| hs_in | input | 1 | Horizontal sync |
| narrow_en | input | 1 | Ignore the two LSBs of each bus |
| bus_a | input | DW | Luma bus, or the shared bus |
| bus_b | input | DW | Chroma bus in two-bus mode |
| pix_valid | output | 1 | Pixel strobe |
| y_out | output | DW | Luma of the pixel |
| cb_out | output | DW | Cb of the pixel |
| cr_out | output | DW | Cr of the pixel |
| cosited | output | 1 | Pixel carries its own chroma sample |

## Verification
A wrong chroma phase shows at the ports as swapped Cb/Cr values, or as a luma value shifted by one sample. It appears two to six clocks after the realignment event, depending on the mode. A stuck sync edge detector or timing-code matcher is exposed by realigning on a deliberately odd phase and checking the first pixel after it. Faults in the pixel sequencer show within one pixel period as a missing or doubled strobe, a wrong co-sited flag, or chroma that changes on the repeated pixel.

// File: rtl/ycc422_pkg.sv
// Shared types for the 4:2:2 demultiplexer.
// Assumes: word positions in the shared-bus cycle start at Cb.
package ycc422_pkg;
    // Position of a word within a chroma cycle; two-bus mode uses only the first two values.
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } ph_t;

    // Progress through the timing-code preamble.
    typedef enum logic [1:0] {
        PRE_IDLE = 2'd0,
        PRE_ONES = 2'd1,
        PRE_Z1   = 2'd2,
        PRE_Z2   = 2'd3
    } pre_t;
endpackage

// File: rtl/ycc_phase_ctrl.sv
// Chroma phase tracker: supplies the position of the word sampled at each edge.
// Realigns on the first active sync clock or on a start-of-active-video code,
// and restarts on a change of bus mode.
// Assumes: code_word is already masked; DW >= 8.
module ycc_phase_ctrl
    import ycc422_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          timing_sel,
    input  logic          hs_pol,
    input  logic          hs_in,
    input  logic [DW-1:0] word_mask,
    input  logic [DW-1:0] code_word,
    output ph_t           phase,
    output logic          restart,
    output logic          realign
);
    localparam int          H_BIT   = DW - 4;
    localparam int          MSB     = DW - 1;
    localparam logic [DW-1:0] ALL_ONE = {DW{1'b1}};

    logic mode_q;
    logic hs_act;
    logic hs_act_q;
    logic sav_q;
    pre_t pre_q;
    ph_t  phase_q;
    logic word_ones;
    logic word_zero;
    logic sav_hit;

    // Sync level relative to the configured polarity.
    assign hs_act    = (hs_in == hs_pol);
    assign word_ones = (code_word == (ALL_ONE & word_mask));
    assign word_zero = (code_word == '0);
    assign sav_hit   = (pre_q == PRE_Z2) && code_word[MSB] && !code_word[H_BIT];

    // Realignment source and the resulting phase for this edge.
    assign restart = (mode_sel != mode_q);
    assign realign = timing_sel ? sav_q : (hs_act && !hs_act_q);
    assign phase   = (restart || realign) ? PH_CB : phase_q;

    // Registered sync level and mode, used for edge and change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_act_q <= 1'b0;
            mode_q   <= mode_sel;
        end else begin
            hs_act_q <= hs_act;
            mode_q   <= mode_sel;
        end
    end

    // Preamble matcher for the embedded timing codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_IDLE;
            sav_q <= 1'b0;
        end else begin
            sav_q <= sav_hit;
            if (word_ones)
                pre_q <= PRE_ONES;
            else if (pre_q == PRE_ONES && word_zero)
                pre_q <= PRE_Z1;
            else if (pre_q == PRE_Z1 && word_zero)
                pre_q <= PRE_Z2;
            else
                pre_q <= PRE_IDLE;
        end
    end

    // Phase counter: modulo 2 with two buses, modulo 4 with a shared bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CB;
        end else if (restart) begin
            phase_q <= PH_CB;
        end else if (!mode_sel) begin
            phase_q <= (phase == PH_CB) ? PH_Y0 : PH_CB;
        end else begin
            phase_q <= ph_t'(phase + 2'd1);
        end
    end

    // R2: in two-bus mode the counter only takes the first two positions.
    assert_two_bus_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && !restart) |=> (mode_sel || phase_q == PH_CB || phase_q == PH_Y0));

endmodule

// File: rtl/ycc_pair_collect.sv
// Gathers Cb, Y0, Cr and Y1 into a pixel pair and raises pair_vld for one clock
// when the pair is complete.
// Assumes: phase comes from ycc_phase_ctrl and the buses are already masked.
module ycc_pair_collect
    import ycc422_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shared,
    input  logic          restart,
    input  ph_t           phase,
    input  logic [DW-1:0] prim,
    input  logic [DW-1:0] sec,
    output logic          pair_vld,
    output logic [DW-1:0] pair_y0,
    output logic [DW-1:0] pair_y1,
    output logic [DW-1:0] pair_cb,
    output logic [DW-1:0] pair_cr
);
    logic [DW-1:0] y0_h;
    logic [DW-1:0] cb_h;
    logic [DW-1:0] cr_h;

    // Capture words by position; publish the pair on its last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y0_h     <= '0;
            cb_h     <= '0;
            cr_h     <= '0;
            pair_vld <= 1'b0;
            pair_y0  <= '0;
            pair_y1  <= '0;
            pair_cb  <= '0;
            pair_cr  <= '0;
        end else begin
            pair_vld <= 1'b0;
            if (!restart) begin
                if (!shared) begin
                    if (phase == PH_CB) begin
                        y0_h <= prim;
                        cb_h <= sec;
                    end else begin
                        pair_y0  <= y0_h;
                        pair_y1  <= prim;
                        pair_cb  <= cb_h;
                        pair_cr  <= sec;
                        pair_vld <= 1'b1;
                    end
                end else begin
                    case (phase)
                        PH_CB: cb_h <= prim;
                        PH_Y0: y0_h <= prim;
                        PH_CR: cr_h <= prim;
                        default: begin
                            pair_y0  <= y0_h;
                            pair_y1  <= prim;
                            pair_cb  <= cb_h;
                            pair_cr  <= cr_h;
                            pair_vld <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R2: a completed pair is never followed by another on the next clock.
    assert_pair_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !pair_vld);

endmodule

// File: rtl/ycc_pixel_seq.sv
// Emits each pixel pair as two pixels: the first carries the co-sited chroma,
// the second repeats it. In shared-bus mode the second pixel follows two clocks
// later, which keeps the pixel rate at half the clock.
// Assumes: pairs arrive no closer than two clocks (two-bus) or four (shared).
module ycc_pixel_seq #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shared,
    input  logic          restart,
    input  logic          pair_vld,
    input  logic [DW-1:0] pair_y0,
    input  logic [DW-1:0] pair_y1,
    input  logic [DW-1:0] pair_cb,
    input  logic [DW-1:0] pair_cr,
    output logic          pix_valid,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out,
    output logic          cosited
);
    logic          pend;
    logic          gap;
    logic [DW-1:0] y1_h;

    // Pixel output sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            gap       <= 1'b0;
            y1_h      <= '0;
            pix_valid <= 1'b0;
            y_out     <= '0;
            cb_out    <= '0;
            cr_out    <= '0;
            cosited   <= 1'b0;
        end else if (restart) begin
            pend      <= 1'b0;
            gap       <= 1'b0;
            pix_valid <= 1'b0;
            cosited   <= 1'b0;
        end else if (pair_vld) begin
            y_out     <= pair_y0;
            cb_out    <= pair_cb;
            cr_out    <= pair_cr;
            cosited   <= 1'b1;
            pix_valid <= 1'b1;
            y1_h      <= pair_y1;
            pend      <= 1'b1;
            gap       <= shared;
        end else if (pend && gap) begin
            gap       <= 1'b0;
            pix_valid <= 1'b0;
            cosited   <= 1'b0;
        end else if (pend) begin
            y_out     <= y1_h;
            cosited   <= 1'b0;
            pix_valid <= 1'b1;
            pend      <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            cosited   <= 1'b0;
        end
    end

    // R3: shared-bus pixels never come on two clocks in a row.
    assert_shared_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shared && pix_valid && !restart) |=> !pix_valid);

    // R10: in two-bus mode a co-sited pixel is followed at once by its partner.
    assert_cosite_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared && pix_valid && cosited && !restart) |=> (pix_valid && !cosited));

    // R10: the partner pixel repeats the chroma pair.
    assert_chroma_repeat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cosited) |-> ($stable(cb_out) && $stable(cr_out)));

    // R10: the co-sited flag is only raised on a valid pixel.
    assert_cosited_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cosited |-> pix_valid);

    // R9: a mode change leaves no pixel after that edge.
    assert_mode_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pix_valid);

endmodule

// File: rtl/ycc422_demux.sv
// Top level of the 4:2:2 input demultiplexer: masks the buses for narrow input,
// tracks chroma phase, collects pixel pairs and sequences them onto the outputs.
// Assumes: DW >= 8; bus_a carries luma or the shared stream and any timing codes.
module ycc422_demux
    import ycc422_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          timing_sel,
    input  logic          hs_pol,
    input  logic          hs_in,
    input  logic          narrow_en,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    output logic          pix_valid,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out,
    output logic          cosited
);
    localparam logic [DW-1:0] FULL_MASK   = {DW{1'b1}};
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-2){1'b1}}, 2'b00};

    logic [DW-1:0] word_mask;
    logic [DW-1:0] prim_m;
    logic [DW-1:0] sec_m;
    ph_t           phase;
    logic          restart;
    logic          realign;
    logic          pair_vld;
    logic [DW-1:0] pair_y0;
    logic [DW-1:0] pair_y1;
    logic [DW-1:0] pair_cb;
    logic [DW-1:0] pair_cr;

    // Narrow input drops the two low bits of every word.
    assign word_mask = narrow_en ? NARROW_MASK : FULL_MASK;
    assign prim_m    = bus_a & word_mask;
    assign sec_m     = bus_b & word_mask;

    ycc_phase_ctrl #(.DW(DW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .timing_sel (timing_sel),
        .hs_pol     (hs_pol),
        .hs_in      (hs_in),
        .word_mask  (word_mask),
        .code_word  (prim_m),
        .phase      (phase),
        .restart    (restart),
        .realign    (realign)
    );

    ycc_pair_collect #(.DW(DW)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .shared   (mode_sel),
        .restart  (restart),
        .phase    (phase),
        .prim     (prim_m),
        .sec      (sec_m),
        .pair_vld (pair_vld),
        .pair_y0  (pair_y0),
        .pair_y1  (pair_y1),
        .pair_cb  (pair_cb),
        .pair_cr  (pair_cr)
    );

    ycc_pixel_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .shared    (mode_sel),
        .restart   (restart),
        .pair_vld  (pair_vld),
        .pair_y0   (pair_y0),
        .pair_y1   (pair_y1),
        .pair_cb   (pair_cb),
        .pair_cr   (pair_cr),
        .pix_valid (pix_valid),
        .y_out     (y_out),
        .cb_out    (cb_out),
        .cr_out    (cr_out),
        .cosited   (cosited)
    );

    // R4: a realigning word starts a pair, so no pair completes on that edge.
    assert_hs_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (realign && !restart) |=> !pair_vld);

endmodule

// File: tb/ycc422_demux_test.sv
module ycc422_demux_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       timing_sel = 1'b0;
    logic       hs_pol = 1'b1;
    logic       hs_in = 1'b0;
    logic       narrow_en = 1'b0;
    logic [9:0] bus_a = '0;
    logic [9:0] bus_b = '0;
    logic       pix_valid;
    logic [9:0] y_out;
    logic [9:0] cb_out;
    logic [9:0] cr_out;
    logic       cosited;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ycc422_demux #(.DW(10)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .timing_sel (timing_sel),
        .hs_pol     (hs_pol),
        .hs_in      (hs_in),
        .narrow_en  (narrow_en),
        .bus_a      (bus_a),
        .bus_b      (bus_b),
        .pix_valid  (pix_valid),
        .y_out      (y_out),
        .cb_out     (cb_out),
        .cr_out     (cr_out),
        .cosited    (cosited)
    );

    typedef struct packed {
        logic       hs;
        logic [9:0] a;
        logic [9:0] b;
        logic       pv;
        logic       cos;
        logic [9:0] y;
        logic [9:0] cb;
        logic [9:0] cr;
    } vec_t;

    // Two-bus, sync timing: entry i drives edge Ei and gives the outputs after it.
    localparam vec_t TBL [12] = '{
        '{1'b1, 10'h100, 10'h040, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000},
        '{1'b1, 10'h104, 10'h0C0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000},
        '{1'b1, 10'h108, 10'h044, 1'b1, 1'b1, 10'h100, 10'h040, 10'h0C0},
        '{1'b1, 10'h10C, 10'h0C4, 1'b1, 1'b0, 10'h104, 10'h040, 10'h0C0},
        '{1'b0, 10'h110, 10'h048, 1'b1, 1'b1, 10'h108, 10'h044, 10'h0C4},
        '{1'b0, 10'h114, 10'h0C8, 1'b1, 1'b0, 10'h10C, 10'h044, 10'h0C4},
        '{1'b0, 10'h118, 10'h04C, 1'b1, 1'b1, 10'h110, 10'h048, 10'h0C8},
        '{1'b1, 10'h11C, 10'h050, 1'b1, 1'b0, 10'h114, 10'h048, 10'h0C8},
        '{1'b1, 10'h120, 10'h0D0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000},
        '{1'b1, 10'h124, 10'h054, 1'b1, 1'b1, 10'h11C, 10'h050, 10'h0D0},
        '{1'b1, 10'h128, 10'h0D4, 1'b1, 1'b0, 10'h120, 10'h050, 10'h0D0},
        '{1'b1, 10'h12C, 10'h058, 1'b1, 1'b1, 10'h124, 10'h054, 10'h0D4}
    };

    task automatic chk(string req, string what, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic px(string req, logic pv, logic [9:0] y, logic [9:0] cb,
                      logic [9:0] cr, logic cos);
        chk(req, "pix_valid", {9'b0, pix_valid}, {9'b0, pv});
        if (pv) begin
            chk(req, "y_out", y_out, y);
            chk(req, "cb_out", cb_out, cb);
            chk(req, "cr_out", cr_out, cr);
        end
        chk(req, "cosited", {9'b0, cosited}, {9'b0, cos});
    endtask

    task automatic tick(logic [9:0] a, logic [9:0] b, logic h);
        bus_a = a;
        bus_b = b;
        hs_in = h;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic m, logic t, logic pol, logic n, logic h);
        rst_n      = 1'b0;
        mode_sel   = m;
        timing_sel = t;
        hs_pol     = pol;
        narrow_en  = n;
        hs_in      = h;
        bus_a      = '0;
        bus_b      = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);

        // R1: outputs after reset.
        do_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1", "pix_valid", {9'b0, pix_valid}, 10'h0);
        chk("R1", "y_out", y_out, 10'h0);
        chk("R1", "cb_out", cb_out, 10'h0);
        chk("R1", "cr_out", cr_out, 10'h0);
        chk("R1", "cosited", {9'b0, cosited}, 10'h0);

        // R2 R4 R10: two-bus table, with a held sync level and a later realignment.
        for (int i = 0; i < 12; i++) begin
            tick(TBL[i].a, TBL[i].b, TBL[i].hs);
            px("R2 R4 R10", TBL[i].pv, TBL[i].y, TBL[i].cb, TBL[i].cr, TBL[i].cos);
        end

        // R3: shared bus, Cb Y0 Cr Y1.
        do_reset(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        tick(10'h080, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h200, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h180, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h204, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h084, 10'h000, 1'b1); px("R3", 1'b1, 10'h200, 10'h080, 10'h180, 1'b1);
        tick(10'h208, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h184, 10'h000, 1'b1); px("R3 R10", 1'b1, 10'h204, 10'h080, 10'h180, 1'b0);
        tick(10'h20C, 10'h000, 1'b1); px("R3", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h088, 10'h000, 1'b1); px("R3", 1'b1, 10'h208, 10'h084, 10'h184, 1'b1);

        // R5: active-low sync realigns on an odd phase.
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        tick(10'h010, 10'h001, 1'b1);
        tick(10'h011, 10'h002, 1'b1);
        tick(10'h012, 10'h003, 1'b1);
        tick(10'h222, 10'h0AA, 1'b0);
        tick(10'h226, 10'h0BB, 1'b0); px("R5", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h000, 10'h000, 1'b0); px("R5", 1'b1, 10'h222, 10'h0AA, 10'h0BB, 1'b1);
        tick(10'h000, 10'h000, 1'b0); px("R5", 1'b1, 10'h226, 10'h0AA, 10'h0BB, 1'b0);

        // R6: start code realigns; a sync edge on a Cr word is ignored.
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        tick(10'h040, 10'h000, 1'b0);
        tick(10'h3FF, 10'h000, 1'b0);
        tick(10'h000, 10'h000, 1'b0);
        tick(10'h000, 10'h000, 1'b0);
        tick(10'h200, 10'h000, 1'b0);
        tick(10'h150, 10'h011, 1'b0);
        tick(10'h154, 10'h022, 1'b1);
        tick(10'h158, 10'h033, 1'b1); px("R6", 1'b1, 10'h150, 10'h011, 10'h022, 1'b1);
        tick(10'h15C, 10'h044, 1'b1); px("R6", 1'b1, 10'h154, 10'h011, 10'h022, 1'b0);
        tick(10'h160, 10'h055, 1'b1); px("R6", 1'b1, 10'h158, 10'h033, 10'h044, 1'b1);

        // R7: end code on the stream leaves the order alone.
        tick(10'h3FF, 10'h000, 1'b1);
        tick(10'h000, 10'h000, 1'b1);
        tick(10'h000, 10'h000, 1'b1);
        tick(10'h240, 10'h000, 1'b1);
        tick(10'h170, 10'h066, 1'b1);
        tick(10'h174, 10'h077, 1'b1);
        tick(10'h178, 10'h088, 1'b1);
        tick(10'h000, 10'h000, 1'b1); px("R7", 1'b1, 10'h174, 10'h077, 10'h088, 1'b1);

        // R8: narrow input, masked code match and masked data.
        do_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        tick(10'h045, 10'h000, 1'b0);
        tick(10'h3FC, 10'h000, 1'b0);
        tick(10'h003, 10'h000, 1'b0);
        tick(10'h002, 10'h000, 1'b0);
        tick(10'h201, 10'h000, 1'b0);
        tick(10'h151, 10'h013, 1'b0);
        tick(10'h156, 10'h027, 1'b0);
        tick(10'h000, 10'h000, 1'b0); px("R8", 1'b1, 10'h150, 10'h010, 10'h024, 1'b1);
        tick(10'h000, 10'h000, 1'b0); px("R8", 1'b1, 10'h154, 10'h010, 10'h024, 1'b0);

        // R9: mode change drops the pending pair and restarts on Cb.
        do_reset(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        tick(10'h111, 10'h011, 1'b1);
        tick(10'h115, 10'h022, 1'b1);
        mode_sel = 1'b1;
        tick(10'h000, 10'h000, 1'b1); px("R9", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h0A1, 10'h000, 1'b1); px("R9", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h301, 10'h000, 1'b1); px("R9", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h1A1, 10'h000, 1'b1); px("R9", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h305, 10'h000, 1'b1); px("R9", 1'b0, 0, 0, 0, 1'b0);
        tick(10'h000, 10'h000, 1'b1); px("R9", 1'b1, 10'h301, 10'h0A1, 10'h1A1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule